// File: doc/BRIEF.md
# Encoded Configurable Routing Multiplexer

This block is a routing multiplexer for a programmable fabric. It picks one of `N_IN` data inputs, or an optional extra input tied to a constant, and drives the pick to a single output. The choice is held in a short register of configuration flip-flops, loaded one bit at a time through a shift chain. The register stores a binary code instead of one bit per input, so it needs fewer configuration cells and fewer shift clocks. A local decoder turns the stored code into one-hot selects, and those selects steer a tree of 2:1 cells.

The flip-flop at the end of the chain drives the serial output. This lets several multiplexers share one configuration path, so a single serial stream can program a whole column of them. Each 2:1 cell passes its first input when its select is high and its second input when the select is low. The datapath from the data inputs to the output has no registers. Only the configuration code is clocked.

Top module: `rmux_top`

## Requirements
- R1: A synchronous active-high reset clears the stored code to 0. After reset, `data_out` follows `data_in[0]` and `cfg_so` is 0.
- R2: On each clock edge with `cfg_en` high, the stored code shifts one place toward its most significant bit and `cfg_si` enters at bit 0. A code therefore loads most significant bit first, over `SEL_W` edges.
- R3: `cfg_so` always equals the most significant bit of the stored code. After an enabled edge it shows the bit that sat one place below the top before that edge, so chains can be cascaded.
- R4: On a clock edge with `cfg_en` low, the stored code keeps its value, whatever `cfg_si` does.
- R5: For a stored code k with k < `N_IN`, `data_out` equals `data_in[k]` with no clock delay.
- R6: When `HAS_CONST` is 1, code `N_IN` selects the extra input, and `data_out` equals `CONST_VAL`.
- R7: A code at or beyond the count of valid inputs drives `data_out` to `CONST_VAL` when `HAS_CONST` is 1, and to 0 otherwise.
- R8: The code width `SEL_W` is ceil(log2(`N_IN` + `HAS_CONST`)), with a minimum of 1. With `N_IN`=6 and `HAS_CONST`=1 it is 3 bits, and code 7 is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset of the stored code |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_si | input | 1 | Serial configuration data in |
| cfg_so | output | 1 | Serial configuration data out (last flip-flop of the chain) |
| data_in | input | N_IN | Datapath inputs |
| data_out | output | 1 | Selected datapath output |

## Verification
The output can change in the same cycle for two separate reasons. A shift edge can change which input is selected, and the datapath inputs can change at the same time. The bench provokes this by changing `data_in` in the same half cycle that it completes a code load. After the edge it judges that `data_out` follows the newly selected input's new value, and not the old code or the old data. It also reads `cfg_so` during a shift to confirm that the chain output moves on the same edge that the selection changes.

// File: rtl/rmux_pkg.sv
package rmux_pkg;

    // Polarity of a 2:1 tree cell: a high select passes the first leg.
    typedef enum logic {
        LEG_SECOND = 1'b0,
        LEG_FIRST  = 1'b1
    } leg_pick_e;

    // Number of configuration bits needed to encode n choices.
    function automatic int code_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Number of leaves in a full binary tree for a given code width.
    function automatic int leaf_count(input int w);
        return 1 << w;
    endfunction

endpackage

// File: rtl/rmux_cfg_chain.sv
module rmux_cfg_chain #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [W-1:0] code,
    output logic         ser_out
);
    logic [W:0] shifted;

    // New bit enters at bit 0; older bits move toward the top.
    assign shifted = {code, ser_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (shift_en) begin
            code <= shifted[W-1:0];
        end
    end

    // The top flip-flop is the end of the chain.
    assign ser_out = code[W-1];
endmodule

// File: rtl/rmux_decoder.sv
module rmux_decoder #(
    parameter int M = 7,
    parameter int W = 3
) (
    input  logic [W-1:0] code,
    output logic [M-1:0] hot
);
    // A code beyond the last valid choice leaves every select low.
    for (genvar k = 0; k < M; k++) begin : g_line
        assign hot[k] = (code == W'(k));
    end
endmodule

// File: rtl/rmux_cell.sv
module rmux_cell
    import rmux_pkg::*;
(
    input  logic      in0,
    input  logic      in1,
    input  leg_pick_e pick,
    output logic      y
);
    assign y = (pick == LEG_FIRST) ? in0 : in1;
endmodule

// File: rtl/rmux_tree.sv
module rmux_tree
    import rmux_pkg::*;
#(
    parameter int M = 7,
    parameter int W = 3
) (
    input  logic [M-1:0] leaf,
    input  logic [M-1:0] hot,
    input  logic         fill,
    output logic         y
);
    localparam int P     = leaf_count(W);
    localparam int NODES = 2 * P - 1;

    // Heap numbering: node i has children 2i+1 (first leg) and 2i+2.
    logic [NODES-1:0] val;
    logic [NODES-1:0] any_hot;

    for (genvar j = 0; j < P; j++) begin : g_leaf
        if (j < M) begin : g_real
            assign val[P-1+j]     = leaf[j];
            assign any_hot[P-1+j] = hot[j];
        end else begin : g_pad
            assign val[P-1+j]     = fill;
            assign any_hot[P-1+j] = 1'b0;
        end
    end

    // With no select high, every cell takes its second leg and the
    // rightmost leaf wins; that leaf is a pad whenever M < P.
    for (genvar i = 0; i < P - 1; i++) begin : g_node
        leg_pick_e pick;
        assign pick       = any_hot[2*i+1] ? LEG_FIRST : LEG_SECOND;
        assign any_hot[i] = any_hot[2*i+1] | any_hot[2*i+2];
        rmux_cell u_cell (
            .in0  (val[2*i+1]),
            .in1  (val[2*i+2]),
            .pick (pick),
            .y    (val[i])
        );
    end

    assign y = val[0];
endmodule

// File: rtl/rmux_top.sv
module rmux_top
    import rmux_pkg::*;
#(
    parameter int   N_IN      = 6,
    parameter bit   HAS_CONST = 1'b1,
    parameter logic CONST_VAL = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic            cfg_si,
    output logic            cfg_so,
    input  logic [N_IN-1:0] data_in,
    output logic            data_out
);
    localparam int M     = N_IN + (HAS_CONST ? 1 : 0);
    localparam int SEL_W = code_width(M);

    logic [SEL_W-1:0] cfg_code;
    logic [M-1:0]     sel_hot;
    logic [M-1:0]     leaves;
    logic             fill_bit;

    if (HAS_CONST) begin : g_const
        assign leaves   = {CONST_VAL, data_in};
        assign fill_bit = CONST_VAL;
    end else begin : g_plain
        assign leaves   = data_in;
        assign fill_bit = 1'b0;
    end

    rmux_cfg_chain #(.W(SEL_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .ser_in   (cfg_si),
        .code     (cfg_code),
        .ser_out  (cfg_so)
    );

    rmux_decoder #(.M(M), .W(SEL_W)) u_dec (
        .code (cfg_code),
        .hot  (sel_hot)
    );

    rmux_tree #(.M(M), .W(SEL_W)) u_tree (
        .leaf (leaves),
        .hot  (sel_hot),
        .fill (fill_bit),
        .y    (data_out)
    );
endmodule

// File: rtl/rmux_checker.sv
module rmux_checker #(
    parameter int   N_IN      = 6,
    parameter bit   HAS_CONST = 1'b1,
    parameter logic CONST_VAL = 1'b0,
    parameter int   W         = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_en,
    input logic            cfg_si,
    input logic            cfg_so,
    input logic [N_IN-1:0] data_in,
    input logic            data_out,
    input logic [W-1:0]    code
);
    localparam int M = N_IN + (HAS_CONST ? 1 : 0);

    logic [W:0] ext;
    logic       fallback;
    assign ext      = {code, cfg_si};
    assign fallback = HAS_CONST ? CONST_VAL : 1'b0;

    // R1: reset clears the code
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> code == '0);

    // R2: an enabled edge shifts the code up by one and takes in the serial bit
    a_r2_shift: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> code == $past(ext[W-1:0]));

    // R3: the chain output shows the bit that sat below the top
    a_r3_chain_out: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_so == $past(ext[W-1]));

    // R4: a disabled edge keeps the code
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(code));

    // R5: a valid data code routes that input
    a_r5_select: assert property (@(posedge clk) disable iff (rst)
        (int'(code) < N_IN) |-> data_out == data_in[int'(code) % N_IN]);

    // R6: the constant code routes the constant
    a_r6_const: assert property (@(posedge clk) disable iff (rst)
        (HAS_CONST && int'(code) == N_IN) |-> data_out == CONST_VAL);

    // R7: an out-of-range code routes the fallback value
    a_r7_fallback: assert property (@(posedge clk) disable iff (rst)
        (int'(code) >= M) |-> data_out == fallback);
endmodule

bind rmux_top rmux_checker #(
    .N_IN      (N_IN),
    .HAS_CONST (HAS_CONST),
    .CONST_VAL (CONST_VAL),
    .W         (SEL_W)
) u_rmux_checker (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_si   (cfg_si),
    .cfg_so   (cfg_so),
    .data_in  (data_in),
    .data_out (data_out),
    .code     (cfg_code)
);

// File: tb/rmux_top_tb_top.sv
module rmux_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN = 6;
    localparam int W    = 3;   // R8: ceil(log2(6+1)) = 3
    localparam int NVEC = 12;

    // Vector layout: {code[2:0], data[5:0], expected}
    localparam logic [9:0] VEC [NVEC] = '{
        {3'd0, 6'b000001, 1'b1},
        {3'd0, 6'b111110, 1'b0},
        {3'd1, 6'b000010, 1'b1},
        {3'd1, 6'b111101, 1'b0},
        {3'd2, 6'b000100, 1'b1},
        {3'd3, 6'b110111, 1'b0},
        {3'd4, 6'b010000, 1'b1},
        {3'd5, 6'b100000, 1'b1},
        {3'd5, 6'b011111, 1'b0},
        {3'd6, 6'b000000, 1'b1},
        {3'd6, 6'b111111, 1'b1},
        {3'd7, 6'b000000, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_en = 1'b0;
    logic            cfg_si = 1'b0;
    logic            cfg_so;
    logic [N_IN-1:0] data_in = '0;
    logic            data_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rmux_top #(.N_IN(N_IN), .HAS_CONST(1'b1), .CONST_VAL(1'b1)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_si   (cfg_si),
        .cfg_so   (cfg_so),
        .data_in  (data_in),
        .data_out (data_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Shift a code in, top bit first; returns at the negedge after the last edge.
    task automatic load_code(input logic [W-1:0] c);
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_si = c[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_si = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        data_in = 6'b000001;
        #1;
        check("R1 out follows input 0", data_out, 1'b1);
        check("R1 chain out low", cfg_so, 1'b0);
        data_in = 6'b111110;
        #1;
        check("R1 out follows input 0 low", data_out, 1'b0);

        // Table walk: R5 valid codes, R6 constant code, R7/R8 code 7
        for (int v = 0; v < NVEC; v++) begin
            load_code(VEC[v][9:7]);
            data_in = VEC[v][6:1];
            #1;
            check($sformatf("R5/R6/R7 vector %0d code %0d", v, VEC[v][9:7]),
                  data_out, VEC[v][0]);
        end

        // R3: chain out is the top bit; one more shift moves it
        load_code(3'd5);
        check("R3 top bit of code 5", cfg_so, 1'b1);
        data_in = 6'b000100;
        @(negedge clk);
        cfg_en = 1'b1;
        cfg_si = 1'b0;
        @(negedge clk);
        cfg_en = 1'b0;
        #1;
        check("R3 chain out after extra shift", cfg_so, 1'b0);
        check("R2 code 5 shifted to 2", data_out, 1'b1);

        // R4: disabled edges ignore the serial input
        data_in = 6'b000100;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cfg_si = ~cfg_si;
        end
        #1;
        check("R4 selection held with enable low", data_out, 1'b1);
        check("R4 chain out held", cfg_so, 1'b0);

        // Same-cycle: finish a load while the data changes
        data_in = 6'b000000;
        @(negedge clk); cfg_en = 1'b1; cfg_si = 1'b0;
        @(negedge clk); cfg_si = 1'b1;
        @(negedge clk); cfg_si = 1'b1;
        data_in = 6'b001000;
        @(negedge clk);
        cfg_en = 1'b0;
        #1;
        check("R2 code 3 routes new data", data_out, 1'b1);
        data_in = 6'b110111;
        #1;
        check("R5 code 3 follows data with no delay", data_out, 1'b0);

        // R1: reset mid-operation returns to input 0
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        data_in = 6'b000001;
        #1;
        check("R1 reset again selects input 0", data_out, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule